// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked system use an external asynchronous static RAM of 2048 bytes. The host side is a simple handshake: the host presents an operation (read or write), an 11-bit word address and 8-bit write data together with a valid flag, and the operation is taken in any cycle in which the controller reports itself ready. A read returns its byte on a result bus, qualified by a valid pulse that lasts one clock.

On the memory side the controller drives the address lines, three active-low strobes (select, write, output) and a split data bus: an output value, an output-drive enable and an input value, to be joined by a tri-state pad outside the block. Every strobe sequence is built from phases whose lengths, in clocks, are derived from nanosecond minimums and the clock period. A write keeps the output strobe inactive for its whole length. The write data is driven only after the write strobe has been low for one clock, and it is held for one clock after the strobe rises. The address changes only while the memory is deselected. When the controller is idle the memory stays deselected, so that it draws only standby power.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all three memory strobes are high (inactive), the data-drive enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Whenever `req_ready` is 1, the select strobe `mem_cs_n` is 1 (standby), and `req_ready` is 1 exactly when no operation is in progress.
- R3: `mem_addr` changes only at a clock edge after which select is high or at which select falls; it never changes while select stays low.
- R4: A write accepted at edge k gives: select low with write high for AS cycles, then select and write both low for WP cycles, then both high for WR recovery cycles, and `req_ready` is 1 again after AS+WP+WR cycles.
- R5: During a write the output strobe `mem_oe_n` stays 1, and the write strobe is low only while select is low.
- R6: `mem_dq_oe` is 1 from the second clock of the write-low interval up to and including the first clock after the write strobe rises, and it is 0 in every other cycle. While it is 1, `mem_dq_out` equals the accepted write data.
- R7: A read accepted at edge k holds select and output strobe low with the write strobe high for AA cycles, then releases both.
- R8: `rsp_valid` is 1 for exactly one cycle, the cycle after the last access cycle. `rsp_rdata` then holds the byte sampled from `mem_dq_in` on the last access cycle.
- R9: The phase lengths are AS = max(1, ceil(setup_ns/period)), WP = max(2, ceil(pulse_ns/period)), WR = max(1, ceil(recovery_ns/period)) and AA = max(1, ceil(access_ns/period)).
- R10: A request presented while `req_ready` is 0 is ignored: it causes no memory cycle, and the stored byte it names is unchanged.
- R11: A byte written to an address is returned by a later read of that address, including at the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host operation present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle; a request is taken this cycle |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 8 | Read result |
| mem_addr | output | 11 | Memory address lines |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_dq_out | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The bench builds the controller with a 10 ns clock and minimums of 5, 25, 12 and 35 ns. These give setup, pulse, recovery and access lengths of 1, 3, 2 and 4 cycles. All four lengths differ, so a phase that runs for the wrong length, or that uses another phase's length, shows up as a strobe mismatch in a specific cycle. A pulse of three cycles also leaves a visible clock at the start of the write-low interval in which the data bus must still be undriven, and it makes the one-clock hold after the rising edge a separate cycle that can be observed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_PULSE  = 3'd2,
    PH_RECOV  = 3'd3,
    PH_ACCESS = 3'd4
  } phase_t;

  // ceiling of ns/period, never below floor_cyc
  function automatic int phase_cycles(input int ns, input int period, input int floor_cyc);
    int c;
    c = (ns + period - 1) / period;
    return (c < floor_cyc) ? floor_cyc : c;
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else              count <= count + 1'b1;
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int AS_CYC = 1,
  parameter int WP_CYC = 2,
  parameter int WR_CYC = 1,
  parameter int AA_CYC = 3,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CW-1:0]     count,
  output logic              req_ready,
  output logic              restart,
  output logic              access_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out
);
  phase_t            ph_q, ph_d;
  logic [CW-1:0]     ph_len;
  logic              ph_last;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    unique case (ph_q)
      PH_SETUP:  ph_len = CW'(AS_CYC);
      PH_PULSE:  ph_len = CW'(WP_CYC);
      PH_RECOV:  ph_len = CW'(WR_CYC);
      PH_ACCESS: ph_len = CW'(AA_CYC);
      default:   ph_len = CW'(1);
    endcase
  end

  assign ph_last = (count == ph_len - 1'b1);
  assign accept  = (ph_q == PH_IDLE) && req_valid;
  assign restart = (ph_q == PH_IDLE) || ph_last;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (req_valid) ph_d = req_write ? PH_SETUP : PH_ACCESS;
      PH_SETUP:  if (ph_last) ph_d = PH_PULSE;
      PH_PULSE:  if (ph_last) ph_d = PH_RECOV;
      PH_RECOV:  if (ph_last) ph_d = PH_IDLE;
      PH_ACCESS: if (ph_last) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign req_ready   = (ph_q == PH_IDLE);
  assign access_done = (ph_q == PH_ACCESS) && ph_last;
  assign mem_addr    = addr_q;
  assign mem_dq_out  = wdata_q;
  assign mem_cs_n    = !((ph_q == PH_SETUP) || (ph_q == PH_PULSE) || (ph_q == PH_ACCESS));
  assign mem_we_n    = (ph_q != PH_PULSE);
  assign mem_oe_n    = (ph_q != PH_ACCESS);
  // drive from second pulse clock, hold one clock past the rising write strobe
  assign mem_dq_oe   = ((ph_q == PH_PULSE) && (count != '0)) ||
                       ((ph_q == PH_RECOV) && (count == '0));
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= din;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 11,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_NS  = 10,
  parameter int ADDR_SETUP_NS  = 0,
  parameter int WRITE_PULSE_NS = 15,
  parameter int WRITE_RECOV_NS = 0,
  parameter int READ_ACCESS_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int AS_CYC = phase_cycles(ADDR_SETUP_NS,  CLK_PERIOD_NS, 1);
  localparam int WP_CYC = phase_cycles(WRITE_PULSE_NS, CLK_PERIOD_NS, 2);
  localparam int WR_CYC = phase_cycles(WRITE_RECOV_NS, CLK_PERIOD_NS, 1);
  localparam int AA_CYC = phase_cycles(READ_ACCESS_NS, CLK_PERIOD_NS, 1);
  localparam int MAX_CYC = max_of4(AS_CYC, WP_CYC, WR_CYC, AA_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);

  logic          restart;
  logic          access_done;
  logic [CW-1:0] count;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .count   (count)
  );

  sram_seq #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .AS_CYC (AS_CYC), .WP_CYC (WP_CYC),
    .WR_CYC (WR_CYC), .AA_CYC (AA_CYC), .CW (CW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .count       (count),
    .req_ready   (req_ready),
    .restart     (restart),
    .access_done (access_done),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_oe   (mem_dq_oe),
    .mem_dq_out  (mem_dq_out)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (access_done),
    .din     (mem_dq_in),
    .rvalid  (rsp_valid),
    .rdata   (rsp_rdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int WP_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  logic [7:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> mem_cs_n); // R2
  AST_ADDR_HELD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (we_low_cnt >= 8'(WP_CYC))); // R4
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_oe_n && !mem_cs_n)); // R5
  AST_DRIVE_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (mem_dq_oe && !mem_we_n) |-> $past(!mem_we_n)); // R6
  AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> mem_dq_oe); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R6
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R8
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
  localparam int CLK_NS = 10;
  localparam int S_NS = 5, P_NS = 25, R_NS = 12, A_NS = 35;
  // R9: expected lengths, worked out independently
  localparam int E_AS = ((S_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (S_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_WP = ((P_NS + CLK_NS - 1) / CLK_NS < 2) ? 2 : (P_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_WR = ((R_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (R_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_AA = ((A_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (A_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [10:0] mem_addr;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] sram [2048];
  logic [7:0] ref_mem [2048];

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_NS(CLK_NS), .ADDR_SETUP_NS(S_NS), .WRITE_PULSE_NS(P_NS),
              .WRITE_RECOV_NS(R_NS), .READ_ACCESS_NS(A_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // behavioural memory on the pins
  always_comb mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? sram[mem_addr] : 8'h00;
  always @(negedge clk) if (!mem_cs_n && !mem_we_n && mem_dq_oe) sram[mem_addr] <= mem_dq_out;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // reference model: phase code and cycles left in the phase
  int m_ph = 0, m_left = 0;
  bit m_rv = 0;
  logic [10:0] m_addr = '0;
  logic [7:0]  m_data = '0, m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 0; m_rv <= 0;
    end else begin
      m_rv <= (m_ph == 4 && m_left == 1);
      if (m_ph == 0) begin
        if (req_valid) begin
          m_addr <= req_addr; m_data <= req_wdata;
          if (req_write) begin m_ph <= 1; m_left <= E_AS; ref_mem[req_addr] <= req_wdata; end
          else begin m_ph <= 4; m_left <= E_AA; end
        end
      end else if (m_left == 1) begin
        case (m_ph)
          1: begin m_ph <= 2; m_left <= E_WP; end
          2: begin m_ph <= 3; m_left <= E_WR; end
          4: begin m_ph <= 0; m_rd <= ref_mem[m_addr]; end
          default: m_ph <= 0;
        endcase
      end else m_left <= m_left - 1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(mem_cs_n == !(m_ph == 1 || m_ph == 2 || m_ph == 4), "R4/R7", "cs_n", mem_cs_n, !(m_ph == 1 || m_ph == 2 || m_ph == 4));
      chk(mem_we_n == (m_ph != 2), "R4", "we_n", mem_we_n, m_ph != 2);
      chk(mem_oe_n == (m_ph != 4), "R5/R7", "oe_n", mem_oe_n, m_ph != 4);
      chk(mem_dq_oe == ((m_ph == 2 && m_left != E_WP) || (m_ph == 3 && m_left == E_WR)), "R6", "dq_oe",
          mem_dq_oe, (m_ph == 2 && m_left != E_WP) || (m_ph == 3 && m_left == E_WR));
      chk(req_ready == (m_ph == 0), "R2/R10", "ready", req_ready, m_ph == 0);
      chk(rsp_valid == m_rv, "R8", "rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk(rsp_rdata == m_rd, "R8/R11", "rdata", rsp_rdata, m_rd);
      if (m_ph != 0) chk(mem_addr == m_addr, "R3", "addr", mem_addr, m_addr);
      if (mem_dq_oe) chk(mem_dq_out == m_data, "R6", "dq_out", mem_dq_out, m_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 50000);
      report();
    end
  end

  task automatic op(input bit w, input int a, input int d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = 11'(a); req_wdata = 8'(d);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin sram[i] = 8'(i * 7 + 3); ref_mem[i] = 8'(i * 7 + 3); end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1", "strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe && req_ready && !rsp_valid, "R1", "oe/ready/valid in reset", {mem_dq_oe, req_ready, rsp_valid}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n && req_ready && !mem_dq_oe, "R1", "first cycle after reset", {mem_cs_n, req_ready, mem_dq_oe}, 3'b110);
    // R9: lengths derived from the ns minimums
    chk(E_AS == 1 && E_WP == 3 && E_WR == 2 && E_AA == 4, "R9", "phase lengths", E_AS*1000+E_WP*100+E_WR*10+E_AA, 1324);
    // R11: boundary addresses and data patterns
    op(1, 0, 8'hA5); op(1, 2047, 8'h5A); op(1, 5, 8'hFF); op(1, 6, 8'h00);
    op(0, 0, 0); op(0, 2047, 0); op(0, 5, 0); op(0, 6, 0);
    op(0, 100, 0);                       // untouched location
    op(1, 9, 8'h3C); op(0, 9, 0);        // back to back
    wait_idle();
    chk(sram[0] == 8'hA5, "R11", "stored low address", sram[0], 8'hA5);
    chk(sram[2047] == 8'h5A, "R11", "stored high address", sram[2047], 8'h5A);
    // R10: a request while busy is ignored
    op(1, 20, 8'h11);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 11'd21; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    chk(sram[21] == 8'(21 * 7 + 3), "R10", "ignored write left memory", sram[21], 8'(21 * 7 + 3));
    op(0, 21, 0);
    wait_idle();
    // mixed traffic
    begin
      int lf = 32'h1F3A;
      for (int n = 0; n < 60; n++) begin
        lf = (lf * 1103515245 + 12345) & 32'h7FFFFFFF;
        op(lf[9], (lf >> 11) & 15, (lf >> 3) & 255);
      end
    end
    wait_idle();
    report();
  end
endmodule